// File: doc/BRIEF.md
# Multi-format PC keyboard scan-code receiver

This block takes the clock and data lines of a legacy PC keyboard and turns each incoming frame into one 8-bit scan code. Three frame shapes are accepted on the same pins with no configuration.

- The clone XT shape is one high start bit and eight data bits.
- The original XT shape is a low start bit, a high start bit and eight data bits.
- The AT shape is a low start bit, eight data bits, an odd parity bit and a high stop bit.

Data bits always arrive least significant first. Both lines are synchronised into the system clock domain, and the data level is captured on every falling edge of the keyboard clock.

Each captured bit enters the top of a 16-bit shift register that moves right. The register is preloaded with a single marker 1 in its top bit. The block has no bit counter. It learns how many bits have arrived from how far the marker has travelled, and it reads the frame shape from the start bits that sit just above the marker.

Two frame shapes cannot be told apart from their bits alone: the original XT frame, and an AT frame whose first data bit is 1. Both show the same ten-bit pattern. The block settles the case by timing. If another falling edge arrives within a short budget, that edge is an AT stop bit. If the budget runs out, the frame is an original XT frame.

A finished frame produces a one-cycle valid strobe together with the byte and a shape code. A broken frame produces a one-cycle error strobe instead.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, `valid_o` and `err_o` are 0, `byte_o` is 0x00 and `ftype_o` is 0.
- R2: A frame of a 1 start bit followed by eight data bits, LSB first, produces one `valid_o` pulse with `byte_o` equal to the data and `ftype_o` = 2.
- R3: A frame of start bits 0 then 1 followed by eight data bits, with no further keyboard clock falling edge for the stop budget (STOP_US microseconds at CLK_HZ), produces one `valid_o` pulse with the data and `ftype_o` = 1.
- R4: A frame of a 0 start bit, eight data bits, a parity bit and a 1 stop bit, with an odd count of ones over data plus parity, produces one `valid_o` pulse with the data and `ftype_o` = 3. When data bit 0 is 1, the stop-bit edge must fall within the stop budget.
- R5: A frame of the R4 shape with an even count of ones over data plus parity produces one `err_o` pulse and no `valid_o` pulse.
- R6: A frame of the R4 shape with a 0 stop bit produces one `err_o` pulse and no `valid_o` pulse.
- R7: A partly received frame followed by no keyboard clock falling edge for IDLE_US microseconds is dropped with one `err_o` pulse. The next frame then decodes correctly.
- R8: `valid_o` and `err_o` are single-cycle pulses and are never high in the same cycle.
- R9: Every byte value, 0xFF included, is delivered through `valid_o`. No data value is reserved to mean "nothing received".
- R10: `byte_o` and `ftype_o` change only in a cycle in which `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kbd_dat_i | input | 1 | Keyboard data line, asynchronous |
| byte_o | output | 8 | Last received scan code, held |
| valid_o | output | 1 | One-cycle strobe: `byte_o` and `ftype_o` are new |
| ftype_o | output | 2 | Frame shape: 1 original XT, 2 clone XT, 3 AT |
| err_o | output | 1 | One-cycle strobe: a frame was rejected or dropped |

## Verification
The hardest situation to reach is the fork between an original XT frame and an AT frame whose first data bit is 1. After ten bits the two leave identical register contents, and only the arrival time of the next edge separates them.

The bench reaches this fork many times. It sweeps every byte value through the AT shape, so half of those frames pass through the timed wait and are closed by a stop edge that lands well inside the budget. It also sweeps byte values through the original XT shape, where each frame ends in silence longer than the budget.

Parity faults, a low stop bit and a frame cut off midway then check the error side.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    typedef enum logic [1:0] {
        FT_NONE     = 2'd0,
        FT_XT_ORIG  = 2'd1,
        FT_XT_CLONE = 2'd2,
        FT_AT       = 2'd3
    } ftype_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_CLONE,
        CL_FORK,
        CL_AT_OK,
        CL_AT_BAD
    } cls_e;

    localparam int unsigned SR_W = 16;
    localparam logic [SR_W-1:0] SR_EMPTY = 16'h8000;

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_raw,
    input  logic dat_raw,
    output logic dat_s,
    output logic fall
);
    logic [STAGES-1:0] clk_chain_q;
    logic [STAGES-1:0] dat_chain_q;
    logic              clk_prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_chain_q <= '1;
                    dat_chain_q <= '1;
                end else begin
                    clk_chain_q <= clk_raw;
                    dat_chain_q <= dat_raw;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_chain_q <= '1;
                    dat_chain_q <= '1;
                end else begin
                    clk_chain_q <= {clk_chain_q[STAGES-2:0], clk_raw};
                    dat_chain_q <= {dat_chain_q[STAGES-2:0], dat_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev_q <= 1'b1;
        else        clk_prev_q <= clk_chain_q[STAGES-1];
    end

    assign dat_s = dat_chain_q[STAGES-1];
    assign fall  = clk_prev_q & ~clk_chain_q[STAGES-1];

endmodule

// File: rtl/kbd_frame_classify.sv
module kbd_frame_classify
    import kbd_rx_pkg::*;
(
    input  logic [SR_W-1:0] sh,
    output cls_e            cls,
    output logic [7:0]      data
);
    logic mark6, mark5, mark4;

    // marker position = lowest set bit of the shifted register
    assign mark6 = sh[6] && (sh[5:0] == 6'd0);
    assign mark5 = sh[5] && (sh[4:0] == 5'd0);
    assign mark4 = sh[4] && (sh[3:0] == 4'd0);

    always_comb begin
        cls  = CL_NONE;
        data = sh[15:8];
        if (mark6 && sh[7]) begin
            cls = CL_CLONE;
        end else if (mark5 && sh[7]) begin
            cls = CL_FORK;
        end else if (mark4) begin
            data = sh[13:6];
            cls  = (sh[15] && (^sh[14:6])) ? CL_AT_OK : CL_AT_BAD;
        end
    end

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned STOP_US = 100,
    parameter int unsigned IDLE_US = 2000,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kbd_clk_i,
    input  logic       kbd_dat_i,
    output logic [7:0] byte_o,
    output logic       valid_o,
    output logic [1:0] ftype_o,
    output logic       err_o
);
    localparam int unsigned CYC_US   = CLK_HZ / 1_000_000;
    localparam int unsigned STOP_CYC = CYC_US * STOP_US;
    localparam int unsigned IDLE_CYC = CYC_US * IDLE_US;
    localparam int unsigned TW       = $clog2(IDLE_CYC + 1);
    localparam logic [TW-1:0] STOP_LIM = TW'(STOP_CYC - 1);
    localparam logic [TW-1:0] IDLE_LIM = TW'(IDLE_CYC - 1);

    typedef struct packed {
        logic [SR_W-1:0] shift;
        logic [TW-1:0]   tmr;
        logic            fork_wait;
        logic [7:0]      rx_byte;
        ftype_e          ftype;
        logic            valid;
        logic            err;
    } st_t;

    st_t  st_d, st_q;
    logic dat_s, fall;
    logic [SR_W-1:0] sh;
    cls_e cls;
    logic [7:0] cls_data;

    kbd_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_raw (kbd_clk_i),
        .dat_raw (kbd_dat_i),
        .dat_s   (dat_s),
        .fall    (fall)
    );

    assign sh = {dat_s, st_q.shift[SR_W-1:1]};

    kbd_frame_classify u_cls (
        .sh   (sh),
        .cls  (cls),
        .data (cls_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (fall) begin
            st_d.shift     = sh;
            st_d.tmr       = '0;
            st_d.fork_wait = 1'b0;
            unique case (cls)
                CL_CLONE: begin
                    st_d.rx_byte = cls_data;
                    st_d.ftype   = FT_XT_CLONE;
                    st_d.valid   = 1'b1;
                    st_d.shift   = SR_EMPTY;
                end
                CL_FORK: st_d.fork_wait = 1'b1;
                CL_AT_OK: begin
                    st_d.rx_byte = cls_data;
                    st_d.ftype   = FT_AT;
                    st_d.valid   = 1'b1;
                    st_d.shift   = SR_EMPTY;
                end
                CL_AT_BAD: begin
                    st_d.err   = 1'b1;
                    st_d.shift = SR_EMPTY;
                end
                default: ;
            endcase
        end else if (st_q.shift != SR_EMPTY) begin
            if (st_q.tmr == (st_q.fork_wait ? STOP_LIM : IDLE_LIM)) begin
                if (st_q.fork_wait) begin
                    st_d.rx_byte = st_q.shift[15:8];
                    st_d.ftype   = FT_XT_ORIG;
                    st_d.valid   = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
                st_d.shift     = SR_EMPTY;
                st_d.tmr       = '0;
                st_d.fork_wait = 1'b0;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end else begin
            st_d.tmr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shift: SR_EMPTY, tmr: '0, fork_wait: 1'b0, rx_byte: 8'h00,
                      ftype: FT_NONE, valid: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic [SR_W-1:0] shift_q;
    logic [TW-1:0]   tmr_q;
    logic            fork_q;
    assign shift_q = st_q.shift;
    assign tmr_q   = st_q.tmr;
    assign fork_q  = st_q.fork_wait;

    assign byte_o  = st_q.rx_byte;
    assign ftype_o = st_q.ftype;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;

endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk #(
    parameter int unsigned TW       = 17,
    parameter int unsigned STOP_CYC = 5000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_o,
    input logic          err_o,
    input logic [7:0]    byte_o,
    input logic [1:0]    ftype_o,
    input logic [15:0]   shift_q,
    input logic [TW-1:0] tmr_q,
    input logic          fork_q
);
    // R8: strobes are exclusive and last one cycle
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R10: outputs hold between deliveries
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(byte_o) && $stable(ftype_o)));

    // R2 R3 R4: every delivery names a frame shape
    a_r4_type_known: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (ftype_o != 2'd0));

    // R7: any finished or dropped frame leaves only the marker
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |-> (shift_q == 16'h8000));

    // R3: the fork wait never overruns its budget
    a_r3_budget: assert property (@(posedge clk) disable iff (!rst_n)
        fork_q |-> (tmr_q < TW'(STOP_CYC)));

endmodule

bind kbd_frame_rx kbd_frame_rx_chk #(.TW(TW), .STOP_CYC(STOP_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_o (valid_o),
    .err_o   (err_o),
    .byte_o  (byte_o),
    .ftype_o (ftype_o),
    .shift_q (shift_q),
    .tmr_q   (tmr_q),
    .fork_q  (fork_q)
);

// File: tb/sim_kbd_frame_rx.sv
`timescale 1ns/1ps
module sim_kbd_frame_rx;
    // Small configuration: 1 cycle per microsecond, so stop budget = 100
    // cycles and idle budget = 2000 cycles.
    localparam int HALF = 6;
    localparam int GAP  = 130;
    localparam int WD   = 180_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic [7:0] byte_o;
    logic       valid_o;
    logic [1:0] ftype_o;
    logic       err_o;

    int nvec = 0;
    int nbad = 0;
    int vcnt = 0;
    int ecnt = 0;
    int both = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kbd_frame_rx #(.CLK_HZ(1_000_000), .STOP_US(100), .IDLE_US(2000)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_clk_i (kclk),
        .kbd_dat_i (kdat),
        .byte_o    (byte_o),
        .valid_o   (valid_o),
        .ftype_o   (ftype_o),
        .err_o     (err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) vcnt++;
            if (err_o) ecnt++;
            if (valid_o && err_o) both++;
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    task automatic send(input logic [10:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            kdat = bits[i];
            repeat (HALF) @(negedge clk);
            kclk = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b1;
        end
        kdat = 1'b1;
    endtask

    task automatic run(input string req, input logic [10:0] bits, input int n,
                       input int gap, input bit exp_err,
                       input logic [7:0] exp_b, input logic [1:0] exp_t);
        int v0 = vcnt;
        int e0 = ecnt;
        bit ok;
        send(bits, n);
        repeat (gap) @(negedge clk);
        nvec++;
        if (exp_err)
            ok = (ecnt == e0 + 1) && (vcnt == v0);
        else
            ok = (vcnt == v0 + 1) && (ecnt == e0) && (byte_o == exp_b) && (ftype_o == exp_t);
        if (!ok) begin
            nbad++;
            $display("FAIL %s: valids=%0d errs=%0d byte=%02h type=%0d, expected valids=%0d errs=%0d byte=%02h type=%0d",
                     req, vcnt - v0, ecnt - e0, byte_o, ftype_o,
                     exp_err ? 0 : 1, exp_err ? 1 : 0, exp_b, exp_t);
        end
    endtask

    function automatic logic [10:0] f_clone(input logic [7:0] d);
        return {2'b00, d, 1'b1};
    endfunction
    function automatic logic [10:0] f_orig(input logic [7:0] d);
        return {1'b0, d, 2'b10};
    endfunction
    function automatic logic [10:0] f_at(input logic [7:0] d, input bit bad_par, input bit stop);
        return {stop, (~^d) ^ bad_par, d, 1'b0};
    endfunction

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset
        nvec++;
        if (valid_o !== 1'b0 || err_o !== 1'b0 || byte_o !== 8'h00 || ftype_o !== 2'd0) begin
            nbad++;
            $display("FAIL R1: valid=%b err=%b byte=%02h type=%0d, expected 0 0 00 0",
                     valid_o, err_o, byte_o, ftype_o);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4: every byte through the AT shape (half of them cross the fork)
        for (int d = 0; d < 256; d++)
            run("R4", f_at(8'(d), 1'b0, 1'b1), 11, GAP, 1'b0, 8'(d), 2'd3);
        // R2: clone XT sweep
        for (int d = 0; d < 256; d += 3)
            run("R2", f_clone(8'(d)), 9, GAP, 1'b0, 8'(d), 2'd2);
        // R3: original XT sweep, each ended by silence past the stop budget
        for (int d = 1; d < 256; d += 3)
            run("R3", f_orig(8'(d)), 10, GAP, 1'b0, 8'(d), 2'd1);
        // R9: all-ones data in every shape
        run("R9", f_clone(8'hFF), 9, GAP, 1'b0, 8'hFF, 2'd2);
        run("R9", f_orig(8'hFF), 10, GAP, 1'b0, 8'hFF, 2'd1);
        run("R9", f_at(8'hFF, 1'b0, 1'b1), 11, GAP, 1'b0, 8'hFF, 2'd3);
        // R5: parity faults, data bit 0 both ways
        run("R5", f_at(8'h5A, 1'b1, 1'b1), 11, GAP, 1'b1, 8'h00, 2'd0);
        run("R5", f_at(8'hA5, 1'b1, 1'b1), 11, GAP, 1'b1, 8'h00, 2'd0);
        // R10: rejected frames left the last good byte in place
        nvec++;
        if (byte_o !== 8'hFF || ftype_o !== 2'd3) begin
            nbad++;
            $display("FAIL R10: byte=%02h type=%0d, expected FF 3", byte_o, ftype_o);
        end
        // R6: low stop bit
        run("R6", f_at(8'h3C, 1'b0, 1'b0), 11, GAP, 1'b1, 8'h00, 2'd0);
        run("R6", f_at(8'hC3, 1'b0, 1'b0), 11, GAP, 1'b1, 8'h00, 2'd0);
        // R7: frame cut after 5 bits, then recovery
        run("R7", f_at(8'h00, 1'b0, 1'b1), 5, 2200, 1'b1, 8'h00, 2'd0);
        run("R7", f_clone(8'h81), 9, GAP, 1'b0, 8'h81, 2'd2);
        run("R7", f_orig(8'h0F), 4, 2200, 1'b1, 8'h00, 2'd0);
        run("R7", f_at(8'h1E, 1'b0, 1'b1), 11, GAP, 1'b0, 8'h1E, 2'd3);
        // R8: strobes never coincided
        nvec++;
        if (both != 0) begin
            nbad++;
            $display("FAIL R8: coincident strobes=%0d, expected 0", both);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule